// File: doc/BRIEF.md
# Linked-Descriptor Packet DMA Channel

This block is one DMA channel that works through a chain of descriptors kept in memory. Each descriptor is four 32-bit words at consecutive word addresses: a link to the next descriptor, a buffer address, a buffer length and a mode/status word. A build-time parameter sets the direction. A transmit build reads the buffer and sends it out as a byte stream. A receive build writes the incoming byte stream into the buffer. When a descriptor is finished, the channel writes the status word back with the ownership flag cleared, so software gets the descriptor back.

Software starts the channel by writing the first descriptor address to a head register while the channel is idle. The channel follows the links for as long as it finds descriptors that hardware owns. It stops at a null link, or at a descriptor that software still owns, and marks the last descriptor it processed with an end-of-queue flag. To resume after a stop, software writes the head register again. The channel records the address of the last finished descriptor and raises a pending flag. Software clears that flag by writing the same address back. In the receive build, a credit counter of free buffers gates the intake of stream data.

Registers, by word index on the register port: 0 control (bit 0 enables), 1 soft reset (bit 0), 2 head pointer, 3 completion pointer, 4 free-buffer count.

Top module: `dma_desc_chan`

## Requirements
- R1: After reset every register reads 0, `mem_req`, `tx_valid` and `rx_ready` are low, and the channel is idle.
- R2: A head-register write starts the channel only when the channel is idle, control bit 0 is 1 and the value is non-zero. While the channel is busy the head register reads the current descriptor address, and it reads 0 when the channel is idle. Any other head write is ignored.
- R3: In the transmit build, the number of bytes sent equals mode bits 10:0. Byte i comes from the word at buffer+4*(i/4), lane i%4, little-endian. `tx_last` is high only on the final byte, and data is held stable while `tx_ready` is low.
- R4: When a descriptor finishes, its mode word (descriptor word 3) is written back with bit 29 (owner) cleared and bits 31:30 and 27:0 kept. The completion register then reads that descriptor's address and `cpl_pend` goes high.
- R5: A zero next pointer (word 0) makes the write-back also set bit 28 (end of queue), after which the channel goes idle.
- R6: The next pointer is read only after the buffer transfer has finished, so a descriptor that software links to the tail during the transfer is processed without a restart.
- R7: A descriptor whose fetched mode bit 29 is 0 is not transferred and its words are not written. If a previous descriptor exists, that descriptor receives bit 28 in its write-back. The channel then goes idle.
- R8: In the receive build, bytes are stored little-endian from the buffer address onward. The write-back sets bits 31 and 30 (start and end of packet), clears bit 29, and puts the stored byte count in bits 10:0.
- R9: In the receive build, bytes beyond the buffer length (word 2) are consumed but not stored, and memory beyond that length is not written. The count then equals the buffer length.
- R10: In the receive build, `rx_ready` stays low while the free-buffer count is 0. A write to register 4 adds its value to the count, and each finished receive descriptor subtracts 1.
- R11: A completion-register write equal to the stored address clears `cpl_pend`. A write of any other value leaves it set.
- R12: Writing 1 to register 1 makes it read 1 for one cycle and 0 afterwards. The channel returns to idle and all registers, including control, read 0.
- R13: After an end-of-queue stop, a new head write starts the channel again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Transmit sink accepts |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the received packet |
| rx_ready | output | 1 | Channel accepts a receive byte |
| cpl_pend | output | 1 | Completion not yet acknowledged |

## Verification
The embedded assertions check the following on every cycle:
- an idle channel stays off the memory and stream interfaces;
- a stalled transmit byte holds steady;
- every write-back clears ownership;
- an end-of-queue write-back leaves the channel idle;
- no receive write goes past the buffer length;
- a receive write-back never finds the credit count at zero;
- a soft reset lands in the idle state.

Only the directed scenarios can show the rest:
- the byte order on the stream;
- the exact status words left in memory;
- following a descriptor linked in during a stalled transfer;
- stopping on a software-owned descriptor;
- the acknowledge rules;
- restarting after a stop.

// File: rtl/dma_desc_chan.sv
module dma_desc_chan #(
  parameter int AW = 16,
  parameter int LW = 11,
  parameter int FW = 8,
  parameter bit RX = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          rx_ready,
  output logic          cpl_pend
);
  localparam logic [2:0] A_CTRL = 3'd0, A_SRST = 3'd1, A_HEAD = 3'd2, A_CPL = 3'd3, A_FREE = 3'd4;
  localparam int OWN = 29, EOQ = 28;

  typedef enum logic [3:0] {
    S_IDLE, S_MODE, S_MODE_W, S_BUF, S_BUF_W, S_LEN, S_LEN_W, S_TRD, S_TRW,
    S_TOUT, S_RX, S_NXT, S_NXT_W, S_PEEK, S_PEEK_W, S_WB
  } st_t;

  st_t st;
  logic          en, srst, eoq;
  logic [AW-1:0] cur, nxt_q, buf_q, cp;
  logic [LW-1:0] cnt, blen_q;
  logic [31:0]   mode_q, nmode_q, wbuf, merged, wb_word;
  logic [FW-1:0] free_cnt;

  wire [LW-1:0] tlen    = mode_q[LW-1:0];
  wire [1:0]    lane    = cnt[1:0];
  wire [AW-1:0] word_at = buf_q + AW'({cnt[LW-1:2], 2'b00});
  wire          store   = cnt < blen_q;
  wire          rx_hs   = rx_valid && rx_ready;
  wire          rx_put  = rx_hs && store && (lane == 2'd3 || rx_last || cnt + 1'b1 == blen_q);
  wire          hd_go   = reg_we && reg_addr == A_HEAD && st == S_IDLE && en && reg_wdata[AW-1:0] != '0;

  assign tx_valid = !RX && st == S_TOUT;
  assign tx_data  = wbuf[8*lane +: 8];
  assign tx_last  = tx_valid && (cnt + 1'b1 == tlen);
  assign rx_ready = RX && st == S_RX && free_cnt != '0;

  always_comb begin
    merged = wbuf;
    merged[8*lane +: 8] = rx_data;
    if (RX) wb_word = {2'b11, 1'b0, eoq, mode_q[27:LW], cnt};
    else    wb_word = {mode_q[31:30], 1'b0, eoq, mode_q[27:0]};
  end

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    case (st)
      S_MODE: begin mem_req = 1'b1; mem_addr = cur + AW'(12); end
      S_BUF:  begin mem_req = 1'b1; mem_addr = cur + AW'(4); end
      S_LEN:  begin mem_req = 1'b1; mem_addr = cur + AW'(8); end
      S_TRD:  begin mem_req = 1'b1; mem_addr = word_at; end
      S_RX:   begin mem_req = rx_put; mem_we = rx_put; mem_addr = word_at; mem_wdata = merged; end
      S_NXT:  begin mem_req = 1'b1; mem_addr = cur; end
      S_PEEK: begin mem_req = 1'b1; mem_addr = nxt_q + AW'(12); end
      S_WB:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur + AW'(12); mem_wdata = wb_word; end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {31'd0, en};
      A_SRST:  reg_rdata = {31'd0, srst};
      A_HEAD:  reg_rdata = 32'(cur);
      A_CPL:   reg_rdata = 32'(cp);
      A_FREE:  reg_rdata = 32'(free_cnt);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st <= S_IDLE; en <= 1'b0; srst <= 1'b0; eoq <= 1'b0; cur <= '0; nxt_q <= '0;
      buf_q <= '0; cp <= '0; cnt <= '0; blen_q <= '0; mode_q <= '0; nmode_q <= '0;
      wbuf <= '0; free_cnt <= '0; cpl_pend <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CTRL) en <= reg_wdata[0];
      if (reg_we && reg_addr == A_SRST) srst <= reg_wdata[0];
      if (reg_we && reg_addr == A_CPL && reg_wdata[AW-1:0] == cp) cpl_pend <= 1'b0;
      free_cnt <= free_cnt + ((reg_we && reg_addr == A_FREE) ? reg_wdata[FW-1:0] : '0)
                           - FW'(RX && st == S_WB);
      case (st)
        S_IDLE:   if (hd_go) begin cur <= reg_wdata[AW-1:0]; st <= S_MODE; end
        S_MODE:   st <= S_MODE_W;
        S_MODE_W: begin
          mode_q <= mem_rdata;
          if (!mem_rdata[OWN]) begin cur <= '0; st <= S_IDLE; end
          else st <= S_BUF;
        end
        S_BUF:    st <= S_BUF_W;
        S_BUF_W:  begin buf_q <= mem_rdata[AW-1:0]; st <= S_LEN; end
        S_LEN:    st <= S_LEN_W;
        S_LEN_W:  begin
          blen_q <= mem_rdata[LW-1:0];
          cnt <= '0;
          if (RX) st <= S_RX;
          else if (tlen == '0) st <= S_NXT;
          else st <= S_TRD;
        end
        S_TRD:    st <= S_TRW;
        S_TRW:    begin wbuf <= mem_rdata; st <= S_TOUT; end
        S_TOUT:   if (tx_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt + 1'b1 == tlen) st <= S_NXT;
          else if (lane == 2'd3) st <= S_TRD;
        end
        S_RX:     if (rx_hs) begin
          if (store) begin wbuf <= merged; cnt <= cnt + 1'b1; end
          if (rx_last) st <= S_NXT;
        end
        S_NXT:    st <= S_NXT_W;
        S_NXT_W:  begin
          nxt_q <= mem_rdata[AW-1:0];
          if (mem_rdata[AW-1:0] == '0) begin eoq <= 1'b1; st <= S_WB; end
          else st <= S_PEEK;
        end
        S_PEEK:   st <= S_PEEK_W;
        S_PEEK_W: begin nmode_q <= mem_rdata; eoq <= !mem_rdata[OWN]; st <= S_WB; end
        S_WB:     begin
          cp <= cur; cpl_pend <= 1'b1; eoq <= 1'b0;
          if (eoq) begin cur <= '0; st <= S_IDLE; end
          else begin cur <= nxt_q; mode_q <= nmode_q; st <= S_BUF; end
        end
        default:  st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) st == S_IDLE |-> !mem_req && !tx_valid && !rx_ready); // R1
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R3
  AST_WB_OWNER: assert property (@(posedge clk) disable iff (!rst_n) st == S_WB |-> mem_we && !mem_wdata[OWN]); // R4
  AST_EOQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) st == S_WB && mem_wdata[EOQ] |=> st == S_IDLE && cur == '0); // R5
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) st == S_RX && mem_we |-> cnt < blen_q); // R9
  AST_FREE_CREDIT: assert property (@(posedge clk) disable iff (!rst_n) RX && st == S_WB |-> free_cnt != '0); // R10
  AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n) srst |=> st == S_IDLE && free_cnt == '0 && !en); // R12
endmodule

// File: tb/tb_dma_desc_chan.sv
module tb_dma_desc_chan;
  localparam int CLK_P = 10;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic sel = 1'b0, we = 1'b0;
  logic [2:0] ra = '0;
  logic [31:0] wd = '0, rd_t, rd_r;
  logic t_req, t_we, r_req, r_we;
  logic [AW-1:0] t_addr, r_addr;
  logic [31:0] t_wd, r_wd, t_rd, r_rd;
  logic tx_valid, tx_last, tx_ready, t_rxr, r_txv, r_txl, rx_ready, t_pend, r_pend;
  logic [7:0] tx_data, r_txd;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0;
  logic hold = 1'b0, bp = 1'b0;
  logic [31:0] memt [0:255];
  logic [31:0] memr [0:255];
  logic pk_en = 1'b0, pk_sel = 1'b0;
  logic [7:0] pk_idx = '0;
  logic [31:0] pk_dat = '0;
  logic [7:0] lg_d [0:63];
  logic lg_l [0:63];
  int nlog = 0, vec = 0, miss = 0;
  bit done = 0;

  dma_desc_chan #(.AW(AW), .RX(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we && !sel), .reg_addr(ra), .reg_wdata(wd), .reg_rdata(rd_t),
    .mem_req(t_req), .mem_we(t_we), .mem_addr(t_addr), .mem_wdata(t_wd), .mem_rdata(t_rd),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_valid(1'b0), .rx_data(8'h00), .rx_last(1'b0), .rx_ready(t_rxr), .cpl_pend(t_pend));

  dma_desc_chan #(.AW(AW), .RX(1'b1)) dut_rx (
    .clk(clk), .rst_n(rst_n), .reg_we(we && sel), .reg_addr(ra), .reg_wdata(wd), .reg_rdata(rd_r),
    .mem_req(r_req), .mem_we(r_we), .mem_addr(r_addr), .mem_wdata(r_wd), .mem_rdata(r_rd),
    .tx_valid(r_txv), .tx_data(r_txd), .tx_last(r_txl), .tx_ready(1'b0),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready), .cpl_pend(r_pend));

  always @(posedge clk) begin
    if (pk_en && !pk_sel) memt[pk_idx] <= pk_dat;
    else if (t_req && t_we) memt[t_addr[9:2]] <= t_wd;
    if (t_req && !t_we) t_rd <= memt[t_addr[9:2]];
    if (pk_en && pk_sel) memr[pk_idx] <= pk_dat;
    else if (r_req && r_we) memr[r_addr[9:2]] <= r_wd;
    if (r_req && !r_we) r_rd <= memr[r_addr[9:2]];
    tx_ready <= hold ? 1'b0 : (bp ? ~tx_ready : 1'b1);
  end

  always @(negedge clk) if (tx_valid && tx_ready && nlog < 64) begin
    lg_d[nlog] = tx_data; lg_l[nlog] = tx_last; nlog = nlog + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin miss++; $display("FAIL %s: got %h expected %h", req, act, exp); end
  endtask

  task automatic wr(input logic s, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); sel = s; ra = a; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic s, input logic [2:0] a, output logic [31:0] v);
    sel = s; ra = a; #1; v = s ? rd_r : rd_t;
  endtask

  task automatic poke(input logic s, input logic [31:0] baddr, input logic [31:0] d);
    @(negedge clk); pk_sel = s; pk_idx = baddr[9:2]; pk_dat = d; pk_en = 1'b1;
    @(negedge clk); pk_en = 1'b0;
  endtask

  task automatic desc(input logic s, input logic [31:0] at, input logic [31:0] nx,
                      input logic [31:0] bf, input logic [31:0] ln, input logic [31:0] md);
    poke(s, at, nx); poke(s, at + 4, bf); poke(s, at + 8, ln); poke(s, at + 12, md);
  endtask

  task automatic wait_idle(input logic s, input string req);
    logic [31:0] v;
    int k;
    k = 0;
    @(negedge clk); rd(s, 3'd2, v);
    while (v != 0 && k < 3000) begin @(negedge clk); rd(s, 3'd2, v); k++; end
    if (k >= 3000) chk({req, " channel idle"}, v, 32'h0);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic lst);
    @(negedge clk); rx_valid = 1'b1; rx_data = b; rx_last = lst;
    while (!rx_ready) @(negedge clk);
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 5; i++) begin rd(1'b0, 3'(i), v); chk("R1 tx reg", v, 0); end
    rd(1'b1, 3'd4, v); chk("R1 rx free", v, 0);
    chk("R1 idle outputs", {t_req, tx_valid, rx_ready, r_req, t_pend}, 0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    int b;
    b = nlog;
    wr(0, 3'd0, 1);
    desc(0, 32'h40, 0, 32'h100, 6, 32'hE0000006);
    poke(0, 32'h100, 32'h44332211); poke(0, 32'h104, 32'h00006655);
    wr(0, 3'd2, 32'h40);
    rd(0, 3'd2, v); chk("R2 head reads current", v, 32'h40);
    wait_idle(0, "R3");
    chk("R3 byte count", nlog - b, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R3 byte value", lg_d[b+i], 8'h11 * (i + 1));
      chk("R3 last flag", lg_l[b+i], i == 5);
    end
    chk("R4 R5 status word", memt[8'h13], 32'hD0000006);
    rd(0, 3'd3, v); chk("R4 completion address", v, 32'h40);
    chk("R4 pending", t_pend, 1);
  endtask

  task automatic t_ack;
    wr(0, 3'd3, 32'h44); @(negedge clk); chk("R11 wrong ack ignored", t_pend, 1);
    wr(0, 3'd3, 32'h40); @(negedge clk); chk("R11 ack clears", t_pend, 0);
  endtask

  task automatic t_append;
    int b;
    logic [7:0] exp [0:7];
    exp = '{8'h11, 8'h22, 8'h33, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E};
    b = nlog;
    desc(0, 32'h40, 0, 32'h100, 3, 32'hE0000003);
    desc(0, 32'h50, 0, 32'h200, 5, 32'hE0000005);
    poke(0, 32'h200, 32'h0D0C0B0A); poke(0, 32'h204, 32'h0000000E);
    @(negedge clk); hold = 1'b1;
    wr(0, 3'd2, 32'h40);
    repeat (12) @(negedge clk);
    chk("R6 stalled before link", nlog - b, 0);
    poke(0, 32'h40, 32'h50);
    @(negedge clk); hold = 1'b0; bp = 1'b1;
    wait_idle(0, "R6");
    bp = 1'b0;
    chk("R6 bytes over chain", nlog - b, 8);
    for (int i = 0; i < 8; i++) chk("R6 chain byte", lg_d[b+i], exp[i]);
    chk("R6 R4 first status no eoq", memt[8'h13], 32'hC0000003);
    chk("R5 tail status", memt[8'h17], 32'hD0000005);
  endtask

  task automatic t_owner;
    logic [31:0] v;
    int b;
    b = nlog;
    desc(0, 32'h40, 32'h50, 32'h100, 2, 32'hE0000002);
    poke(0, 32'h5C, 32'hC0000004);
    wr(0, 3'd2, 32'h40);
    wait_idle(0, "R7");
    chk("R7 only first sent", nlog - b, 2);
    chk("R7 eoq on previous", memt[8'h13], 32'hD0000002);
    chk("R7 sw-owned untouched", memt[8'h17], 32'hC0000004);
    b = nlog;
    wr(0, 3'd2, 32'h50);
    repeat (10) @(negedge clk);
    rd(0, 3'd2, v); chk("R7 first not owned idle", v, 0);
    chk("R7 nothing sent", nlog - b, 0);
    rd(0, 3'd3, v); chk("R7 completion unchanged", v, 32'h40);
    b = nlog;
    poke(0, 32'h40, 0); poke(0, 32'h4C, 32'hE0000001);
    wr(0, 3'd2, 32'h40);
    wait_idle(0, "R13");
    chk("R13 restart sends", nlog - b, 1);
    chk("R13 restart status", memt[8'h13], 32'hD0000001);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    int b;
    b = nlog;
    poke(0, 32'h4C, 32'hE0000001);
    wr(0, 3'd0, 0);
    wr(0, 3'd2, 32'h40);
    rd(0, 3'd2, v); chk("R2 head ignored when disabled", v, 0);
    repeat (15) @(negedge clk);
    chk("R2 no bytes when disabled", nlog - b, 0);
    chk("R2 descriptor untouched", memt[8'h13], 32'hE0000001);
    wr(0, 3'd0, 1);
    wr(0, 3'd2, 0);
    rd(0, 3'd2, v); chk("R2 zero head ignored", v, 0);
  endtask

  task automatic t_srst;
    logic [31:0] v;
    wr(0, 3'd1, 1);
    rd(0, 3'd1, v); chk("R12 reset reads 1", v, 1);
    @(negedge clk); rd(0, 3'd1, v); chk("R12 reset self-clears", v, 0);
    rd(0, 3'd0, v); chk("R12 control cleared", v, 0);
    rd(0, 3'd3, v); chk("R12 completion cleared", v, 0);
    chk("R12 pending cleared", t_pend, 0);
  endtask

  task automatic t_rx_basic;
    logic [31:0] v;
    wr(1, 3'd0, 1);
    desc(1, 32'h40, 0, 32'h100, 16, 32'h20000000);
    wr(1, 3'd2, 32'h40);
    repeat (10) @(negedge clk);
    chk("R10 no credit no ready", rx_ready, 0);
    wr(1, 3'd4, 2);
    rd(1, 3'd4, v); chk("R10 credit added", v, 2);
    for (int i = 1; i <= 5; i++) send_rx(8'hA0 + 8'(i), i == 5);
    wait_idle(1, "R8");
    chk("R8 word 0", memr[64], 32'hA4A3A2A1);
    chk("R8 word 1 low byte", {24'h0, memr[65][7:0]}, 32'hA5);
    chk("R8 status word", memr[19], 32'hD0000005);
    rd(1, 3'd4, v); chk("R10 credit consumed", v, 1);
  endtask

  task automatic t_rx_trunc;
    logic [31:0] v;
    poke(1, 32'h100, 0); poke(1, 32'h104, 32'hDEADBEEF);
    desc(1, 32'h40, 0, 32'h100, 3, 32'h20000000);
    wr(1, 3'd2, 32'h40);
    for (int i = 1; i <= 6; i++) send_rx(8'hB0 + 8'(i), i == 6);
    wait_idle(1, "R9");
    chk("R9 stored bytes", {8'h0, memr[64][23:0]}, 32'h00B3B2B1);
    chk("R9 beyond buffer untouched", memr[65], 32'hDEADBEEF);
    chk("R9 status truncated", memr[19], 32'hD0000003);
    rd(1, 3'd4, v); chk("R10 credit zero", v, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_ack;
    t_append;
    t_owner;
    t_disabled;
    t_srst;
    t_rx_basic;
    t_rx_trunc;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vec++; miss++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end
endmodule